// File: doc/BRIEF.md
# Ethernet PHY Discovery and Link Mode Resolver

This block finds an external Ethernet PHY and sets the MAC's speed and duplex to match the link the PHY negotiated. It talks to the PHY through a simple management-register port. It presents an address word and pulses a go strobe. It then waits for the busy flag to drop and takes the returned 16-bit data word. Serial bit timing on the management wires is left to the port behind it.

A pulse on `start` begins a scan of PHY addresses in ascending order, starting at 0. At each address the block reads the upper identifier register. A value of all ones or all zeros means no device is present, and the scan moves on. At the first address that responds, the block reads the lower identifier register and reports the combined identifier and the address. It then reads the local ability register and the link-partner ability register. It ANDs the two words and decodes speed and duplex from the result.

The speed and duplex bits are held inside the block. A write strobe to the MAC control register is raised only when one of those bits actually changes. If no address responds, a probe-failed flag is raised. If a management transaction stays busy too long, it is abandoned and a timeout flag is raised.

Top module: `mii_link_probe`

## Requirements
- R1: The management address word `mgmt_addr` is `{phy_address[4:0], register[4:0]}`, i.e. the PHY address shifted left by 5, ORed with the register number. The registers read are 2 (upper identifier), 3 (lower identifier), 4 (local abilities) and 5 (partner abilities).
- R2: `mgmt_go` is a single-cycle pulse. At most one transaction is outstanding at a time. Returned data is taken only in a cycle where `mgmt_busy` is low, two or more cycles after the go pulse, so data shown while busy is high is never used.
- R3: The reported identifier `phy_id` (28 bits) equals `(reg2 << 12) | (reg3 >> 4)`, taken from the address that was found.
- R4: Addresses are probed from 0 upward. An address whose register 2 reads 0xFFFF or 0x0000 is skipped. The first other address is reported in `phy_addr` with `phy_found` = 1, and a run that finds address A issues exactly A+4 go pulses.
- R5: If all 32 addresses are empty, `probe_fail` = 1 and `phy_found` = 0 at `done`. Exactly 32 transactions are issued and the MAC bits are not written.
- R6: The negotiated word is (register 4 AND register 5). `mac_speed100` becomes 1 when any of bits 9, 8 or 7 (mask 0x0380) of that word is set, and 0 otherwise.
- R7: `mac_full_duplex` becomes 1 when bit 8 of the negotiated word is set, or when bits 8..6 of it equal exactly 3'b001 (masked with 0x01C0 the word equals 0x0040). Otherwise it becomes 0.
- R8: When register 5 reads 0xFFFF, `no_link` = 1 at `done`, and speed and duplex keep their previous values.
- R9: `mac_ctrl_wr` pulses for one cycle, together with `done`, only when the resolved speed or duplex differs from the value currently held. When both already match, no pulse occurs.
- R10: A transaction whose busy flag stays high for BUSY_LIMIT polled cycles is abandoned. `mgmt_timeout` = 1, `done` pulses, and the block returns to idle.
- R11: After reset every output is 0.
- R12: A `start` pulse while a run is in progress is ignored. The run's transaction count and its single `done` pulse are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe-and-resolve run |
| mgmt_addr | output | 10 | Management address word {PHY, register} |
| mgmt_go | output | 1 | One-cycle transaction strobe |
| mgmt_busy | input | 1 | Transaction in progress |
| mgmt_rdata | input | 16 | Read data, valid once busy is low |
| mac_speed100 | output | 1 | MAC speed bit (1 = 100 Mb/s) |
| mac_full_duplex | output | 1 | MAC duplex bit (1 = full) |
| mac_ctrl_wr | output | 1 | MAC control write strobe on change |
| phy_addr | output | 5 | Address of the PHY that was found |
| phy_id | output | 28 | Combined PHY identifier |
| phy_found | output | 1 | A PHY responded in the last run |
| probe_fail | output | 1 | No address responded |
| no_link | output | 1 | Partner register read all ones |
| mgmt_timeout | output | 1 | Last run aborted on a stuck busy flag |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The assertions assume that the management port raises `mgmt_busy` in the cycle after it sees `mgmt_go`. They also assume it never lowers busy on a transaction it was not asked for, so any busy level seen in the poll window belongs to the current request. The bench's PHY model follows this rule. It raises busy on the clock edge that samples go and holds it for a latency of zero to three extra cycles. It places a decoy value on the data lines while busy is high and the real register value only when busy falls. A hang mode keeps busy high to exercise the abort path.

// File: rtl/mii_probe_pkg.sv
package mii_probe_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_ID_HI, SQ_ID_LO, SQ_ADV, SQ_LP, SQ_RES
  } seq_t;

  typedef enum logic [1:0] {
    MX_IDLE, MX_GO, MX_GAP, MX_POLL
  } mx_t;

  localparam int REG_ID_HI = 2;
  localparam int REG_ID_LO = 3;
  localparam int REG_ADV   = 4;
  localparam int REG_LP    = 5;
endpackage

// File: rtl/mgmt_xact.sv
module mgmt_xact
  import mii_probe_pkg::*;
#(
  parameter int PHY_AW     = 5,
  parameter int REG_AW     = 5,
  parameter int DATA_W     = 16,
  parameter int BUSY_LIMIT = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [PHY_AW-1:0]        req_phy,
  input  logic [REG_AW-1:0]        req_reg,
  output logic                     ready,
  output logic                     done_q,
  output logic                     err_q,
  output logic [DATA_W-1:0]        data_q,
  output logic [PHY_AW+REG_AW-1:0] mgmt_addr,
  output logic                     mgmt_go,
  input  logic                     mgmt_busy,
  input  logic [DATA_W-1:0]        mgmt_rdata
);
  localparam int CW = $clog2(BUSY_LIMIT + 1);

  mx_t          st;
  logic [CW-1:0] wait_cnt;

  assign ready = (st == MX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MX_IDLE;
      wait_cnt  <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      data_q    <= '0;
      mgmt_addr <= '0;
      mgmt_go   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        MX_IDLE: begin
          if (req) begin
            mgmt_addr <= {req_phy, req_reg};
            mgmt_go   <= 1'b1;
            err_q     <= 1'b0;
            st        <= MX_GO;
          end
        end
        MX_GO: begin
          mgmt_go <= 1'b0;
          st      <= MX_GAP;
        end
        MX_GAP: begin
          wait_cnt <= '0;
          st       <= MX_POLL;
        end
        MX_POLL: begin
          if (!mgmt_busy) begin
            data_q <= mgmt_rdata;
            done_q <= 1'b1;
            st     <= MX_IDLE;
          end else if (wait_cnt == CW'(BUSY_LIMIT - 1)) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            st     <= MX_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: st <= MX_IDLE;
      endcase
    end
  end

  // R2
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mgmt_go |=> !mgmt_go);

  // R2
  capture_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q) |-> !$past(mgmt_busy));

  // R10
  abort_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> $past(mgmt_busy));
endmodule

// File: rtl/link_mode_dec.sv
module link_mode_dec #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] adv,
  input  logic [DATA_W-1:0] partner,
  output logic              dead,
  output logic              spd100,
  output logic              fdx
);
  localparam logic [DATA_W-1:0] FAST_MASK = DATA_W'('h0380);
  localparam logic [DATA_W-1:0] DUP_MASK  = DATA_W'('h01C0);
  localparam logic [DATA_W-1:0] HALF10_FD = DATA_W'('h0040);
  localparam logic [DATA_W-1:0] FAST_FD   = DATA_W'('h0100);

  logic [DATA_W-1:0] common;

  always_comb begin
    common = adv & partner;
    dead   = (partner == {DATA_W{1'b1}});
    spd100 = |(common & FAST_MASK);
    fdx    = (|(common & FAST_FD)) || ((common & DUP_MASK) == HALF10_FD);
  end
endmodule

// File: rtl/mii_link_probe.sv
module mii_link_probe
  import mii_probe_pkg::*;
#(
  parameter int PHY_AW     = 5,
  parameter int REG_AW     = 5,
  parameter int DATA_W     = 16,
  parameter int BUSY_LIMIT = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  output logic [PHY_AW+REG_AW-1:0] mgmt_addr,
  output logic                     mgmt_go,
  input  logic                     mgmt_busy,
  input  logic [DATA_W-1:0]        mgmt_rdata,
  output logic                     mac_speed100,
  output logic                     mac_full_duplex,
  output logic                     mac_ctrl_wr,
  output logic [PHY_AW-1:0]        phy_addr,
  output logic [2*DATA_W-5:0]      phy_id,
  output logic                     phy_found,
  output logic                     probe_fail,
  output logic                     no_link,
  output logic                     mgmt_timeout,
  output logic                     busy,
  output logic                     done
);
  localparam int                ID_W     = 2*DATA_W - 4;
  localparam logic [PHY_AW-1:0] LAST_PHY = {PHY_AW{1'b1}};

  seq_t              st;
  logic              waiting;
  logic [PHY_AW-1:0] cur_phy;
  logic [DATA_W-1:0] id_hi_q, adv_q, lp_q;
  logic              x_req, x_ready, x_done, x_err;
  logic [DATA_W-1:0] x_data;
  logic [REG_AW-1:0] x_reg;
  logic              r_dead, r_spd, r_fdx;
  logic              rd_state, empty_slot;

  always_comb begin
    rd_state = (st == SQ_ID_HI) || (st == SQ_ID_LO) || (st == SQ_ADV) || (st == SQ_LP);
    x_req    = rd_state && !waiting;
    case (st)
      SQ_ID_LO: x_reg = REG_AW'(REG_ID_LO);
      SQ_ADV:   x_reg = REG_AW'(REG_ADV);
      SQ_LP:    x_reg = REG_AW'(REG_LP);
      default:  x_reg = REG_AW'(REG_ID_HI);
    endcase
    empty_slot = (x_data == '0) || (x_data == {DATA_W{1'b1}});
  end

  mgmt_xact #(
    .PHY_AW(PHY_AW), .REG_AW(REG_AW), .DATA_W(DATA_W), .BUSY_LIMIT(BUSY_LIMIT)
  ) u_xact (
    .clk(clk), .rst(rst), .req(x_req), .req_phy(cur_phy), .req_reg(x_reg),
    .ready(x_ready), .done_q(x_done), .err_q(x_err), .data_q(x_data),
    .mgmt_addr(mgmt_addr), .mgmt_go(mgmt_go), .mgmt_busy(mgmt_busy),
    .mgmt_rdata(mgmt_rdata)
  );

  link_mode_dec #(.DATA_W(DATA_W)) u_dec (
    .adv(adv_q), .partner(lp_q), .dead(r_dead), .spd100(r_spd), .fdx(r_fdx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st              <= SQ_IDLE;
      waiting         <= 1'b0;
      cur_phy         <= '0;
      id_hi_q         <= '0;
      adv_q           <= '0;
      lp_q            <= '0;
      mac_speed100    <= 1'b0;
      mac_full_duplex <= 1'b0;
      mac_ctrl_wr     <= 1'b0;
      phy_addr        <= '0;
      phy_id          <= '0;
      phy_found       <= 1'b0;
      probe_fail      <= 1'b0;
      no_link         <= 1'b0;
      mgmt_timeout    <= 1'b0;
      busy            <= 1'b0;
      done            <= 1'b0;
    end else begin
      done        <= 1'b0;
      mac_ctrl_wr <= 1'b0;
      if (x_req && x_ready) waiting <= 1'b1;
      if (rd_state && x_done) begin
        waiting <= 1'b0;
        if (x_err) begin
          mgmt_timeout <= 1'b1;
          done         <= 1'b1;
          busy         <= 1'b0;
          st           <= SQ_IDLE;
        end else begin
          case (st)
            SQ_ID_HI: begin
              if (!empty_slot) begin
                id_hi_q <= x_data;
                st      <= SQ_ID_LO;
              end else if (cur_phy == LAST_PHY) begin
                probe_fail <= 1'b1;
                done       <= 1'b1;
                busy       <= 1'b0;
                st         <= SQ_IDLE;
              end else begin
                cur_phy <= cur_phy + 1'b1;
              end
            end
            SQ_ID_LO: begin
              phy_id    <= ID_W'({id_hi_q, x_data[DATA_W-1:4]});
              phy_addr  <= cur_phy;
              phy_found <= 1'b1;
              st        <= SQ_ADV;
            end
            SQ_ADV: begin
              adv_q <= x_data;
              st    <= SQ_LP;
            end
            default: begin
              lp_q <= x_data;
              st   <= SQ_RES;
            end
          endcase
        end
      end else begin
        case (st)
          SQ_IDLE: begin
            if (start) begin
              cur_phy      <= '0;
              phy_addr     <= '0;
              phy_id       <= '0;
              phy_found    <= 1'b0;
              probe_fail   <= 1'b0;
              no_link      <= 1'b0;
              mgmt_timeout <= 1'b0;
              busy         <= 1'b1;
              st           <= SQ_ID_HI;
            end
          end
          SQ_RES: begin
            if (r_dead) begin
              no_link <= 1'b1;
            end else if ((r_spd != mac_speed100) || (r_fdx != mac_full_duplex)) begin
              mac_speed100    <= r_spd;
              mac_full_duplex <= r_fdx;
              mac_ctrl_wr     <= 1'b1;
            end
            done <= 1'b1;
            busy <= 1'b0;
            st   <= SQ_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  // R5
  fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    probe_fail |-> !phy_found);

  // R9
  wr_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    mac_ctrl_wr |-> (done && !no_link));

  // R8
  nolink_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && no_link) |-> ($stable(mac_speed100) && $stable(mac_full_duplex)));

  // R4
  adv_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (mgmt_go && mgmt_addr[REG_AW-1:0] == REG_AW'(REG_ADV))
      |-> (phy_found && mgmt_addr[PHY_AW+REG_AW-1:REG_AW] == phy_addr));
endmodule

// File: tb/sim_mii_link_probe.sv
`timescale 1ns/1ps
module sim_mii_link_probe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [9:0]  mgmt_addr;
  logic        mgmt_go;
  logic        mgmt_busy;
  logic [15:0] mgmt_rdata;
  logic        mac_speed100, mac_full_duplex, mac_ctrl_wr;
  logic [4:0]  phy_addr;
  logic [27:0] phy_id;
  logic        phy_found, probe_fail, no_link, mgmt_timeout, busy, done;

  always #2.5 clk = ~clk;

  mii_link_probe u0 (
    .clk(clk), .rst(rst), .start(start),
    .mgmt_addr(mgmt_addr), .mgmt_go(mgmt_go), .mgmt_busy(mgmt_busy),
    .mgmt_rdata(mgmt_rdata), .mac_speed100(mac_speed100),
    .mac_full_duplex(mac_full_duplex), .mac_ctrl_wr(mac_ctrl_wr),
    .phy_addr(phy_addr), .phy_id(phy_id), .phy_found(phy_found),
    .probe_fail(probe_fail), .no_link(no_link), .mgmt_timeout(mgmt_timeout),
    .busy(busy), .done(done)
  );

  // PHY model
  logic        have_phy = 1'b0;
  logic        hang = 1'b0;
  logic [4:0]  m_pa = '0;
  logic [15:0] m_adv = '0, m_lp = '0;
  logic [1:0]  m_lat = '0;
  logic [1:0]  cnt;
  logic [9:0]  lat_addr;

  function automatic logic [15:0] reg_val(input logic [9:0] a);
    logic [4:0] pa = a[9:5];
    logic [4:0] rg = a[4:0];
    if (have_phy && pa == m_pa) begin
      case (rg)
        5'd2: return 16'h0180 | {11'd0, pa};
        5'd3: return 16'hB8A0 ^ {7'd0, pa, 4'd0};
        5'd4: return m_adv;
        5'd5: return m_lp;
        default: return 16'h0000;
      endcase
    end
    if (rg == 5'd2) return pa[0] ? 16'hFFFF : 16'h0000;
    return 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mgmt_busy  <= 1'b0;
      mgmt_rdata <= '0;
      cnt        <= '0;
      lat_addr   <= '0;
    end else if (mgmt_go) begin
      mgmt_busy  <= 1'b1;
      mgmt_rdata <= 16'hDEAD;
      cnt        <= m_lat;
      lat_addr   <= mgmt_addr;
    end else if (mgmt_busy && !hang) begin
      if (cnt == 0) begin
        mgmt_busy  <= 1'b0;
        mgmt_rdata <= reg_val(lat_addr);
      end else cnt <= cnt - 1'b1;
    end
  end

  // Monitors
  int go_cnt = 0, wr_cnt = 0, done_cnt = 0, bad_addr = 0;
  logic [9:0] first_go;
  always @(negedge clk) begin
    if (mgmt_go) begin
      if (go_cnt == 0) first_go = mgmt_addr;
      // R1: register 4 and 5 reads must target the expected PHY
      if ((mgmt_addr[4:0] == 5'd4 || mgmt_addr[4:0] == 5'd5) && mgmt_addr[9:5] != m_pa)
        bad_addr++;
      go_cnt++;
    end
    if (mac_ctrl_wr) wr_cnt++;
    if (done) done_cnt++;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input bit extra_start);
    int guard;
    go_cnt = 0; wr_cnt = 0; done_cnt = 0; bad_addr = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (!done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (extra_start && guard == 12) start = 1'b1;
      else start = 1'b0;
    end
    if (guard >= 5000) chk("watchdog", 32'd1, 32'd0);
    @(negedge clk);
    @(negedge clk);
  endtask

  typedef struct packed {
    logic [4:0]  pa;
    logic [15:0] adv;
    logic [15:0] lp;
    logic        spd;
    logic        fdx;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'd0,  16'h01E1, 16'h01E1, 1'b1, 1'b1},
    '{5'd5,  16'h01E1, 16'h0021, 1'b0, 1'b0},
    '{5'd31, 16'h01E1, 16'h0061, 1'b0, 1'b1},
    '{5'd17, 16'h01E1, 16'h00A1, 1'b1, 1'b0},
    '{5'd17, 16'h01E1, 16'h00A1, 1'b1, 1'b0},
    '{5'd3,  16'h01E1, 16'hFFFF, 1'b1, 1'b0},
    '{5'd8,  16'h0021, 16'h01E1, 1'b0, 1'b0},
    '{5'd12, 16'h01E1, 16'h00C1, 1'b1, 1'b0},
    '{5'd1,  16'h0061, 16'h0041, 1'b0, 1'b1},
    '{5'd30, 16'h0201, 16'h0201, 1'b1, 1'b0}
  };

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic cur_spd, cur_fdx, exp_wr, dead;
    logic [15:0] eh, el;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 outputs", {mgmt_go, mac_speed100, mac_full_duplex, mac_ctrl_wr, phy_found,
                        probe_fail, no_link, mgmt_timeout, busy, done}, 32'd0);
    chk("R11 addr/id", {phy_addr, phy_id[26:0]}, 32'd0);

    cur_spd = 1'b0; cur_fdx = 1'b0;
    have_phy = 1'b1;
    for (int i = 0; i < NV; i++) begin
      m_pa = VEC[i].pa; m_adv = VEC[i].adv; m_lp = VEC[i].lp; m_lat = 2'(i % 4);
      run(1'b0);
      dead   = (VEC[i].lp == 16'hFFFF);
      exp_wr = !dead && ({VEC[i].spd, VEC[i].fdx} != {cur_spd, cur_fdx});
      eh = 16'h0180 | {11'd0, VEC[i].pa};
      el = 16'hB8A0 ^ {7'd0, VEC[i].pa, 4'd0};
      chk("R4 found", {phy_found, probe_fail}, 32'b10);
      chk("R4 address", phy_addr, VEC[i].pa);
      chk("R4 go count", go_cnt, VEC[i].pa + 4);
      chk("R1 first address word", first_go, 32'h002);
      chk("R1 ability address", bad_addr, 0);
      chk("R3 identifier", phy_id, {eh, el[15:4]});
      chk("R6 speed", mac_speed100, VEC[i].spd);
      chk("R7 duplex", mac_full_duplex, VEC[i].fdx);
      chk("R8 no_link", no_link, dead);
      chk("R9 write strobes", wr_cnt, exp_wr);
      cur_spd = VEC[i].spd; cur_fdx = VEC[i].fdx;
    end

    // R12: second start mid-run
    m_pa = 5'd9; m_adv = 16'h01E1; m_lp = 16'h01E1; m_lat = 2'd1;
    run(1'b1);
    chk("R12 go count", go_cnt, 13);
    chk("R12 done count", done_cnt, 1);
    chk("R9 change 100 full", {mac_speed100, mac_full_duplex, 8'(wr_cnt)}, {2'b11, 8'd1});

    // R5: no PHY anywhere
    have_phy = 1'b0;
    run(1'b0);
    chk("R5 flags", {probe_fail, phy_found, no_link}, 32'b100);
    chk("R5 go count", go_cnt, 32);
    chk("R5 no MAC write", {wr_cnt[7:0], mac_speed100, mac_full_duplex}, {8'd0, 2'b11});

    // R10: busy never falls
    have_phy = 1'b1; m_pa = 5'd2; hang = 1'b1;
    run(1'b0);
    chk("R10 timeout flag", {mgmt_timeout, phy_found, probe_fail}, 32'b100);
    chk("R10 single transaction", go_cnt, 1);
    chk("R10 done once", done_cnt, 1);
    hang = 1'b0;
    repeat (6) @(negedge clk);
    // R10 recovery: next run clears the flag
    m_lp = 16'h0021; m_adv = 16'h0021; m_lat = 2'd0;
    run(1'b0);
    chk("R10 flag cleared", {mgmt_timeout, phy_found}, 32'b01);
    chk("R7 10 half after recovery", {mac_speed100, mac_full_duplex}, 32'b00);

    // R2: go pulse count matches with zero latency and decoy never captured
    chk("R2 go count", go_cnt, 6);
    chk("R2 not decoy", phy_id[27:12] != 16'hDEAD, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule